// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block sits beside a FIFO-capable serial channel and turns its pending interrupt conditions into the one read-only interrupt status byte that software polls. Seven sources arrive from the rest of the channel. Six of them are levels held by their owners: line error, receive data ready (or trigger level reached), receive timeout, modem status change, flow-off/special character seen, and handshake-line change. The seventh is a pulse that marks the transmit holding register going empty. Each source is masked by its own enable bit. A fixed priority then picks a single winner, and its code is placed in the low six bits of the byte.

The upper two bits copy the FIFO-enable setting. Bit 0 is an active-low "interrupt pending" flag. An extended-mode flag decides whether the two newer levels (flow-off character and handshake change) can be reported at all. The transmit-empty source is the only one the block stores itself. A read that returns the transmit-empty code clears that stored flag, so the next pending source shows up on the following read. The status byte is registered and follows its inputs with one cycle of latency.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and on the first cycle after it, statusByte reads 0x01.
- R2: One cycle after any edge, statusByte[7:6] read 2'b11 if fifoEnable was 1 at that edge, and 2'b00 otherwise, whatever sources are pending.
- R3: statusByte[0] reads 0 when at least one unmasked source was pending at the previous edge. Otherwise statusByte[5:0] reads 6'b000001.
- R4: The reported code belongs to the highest-priority unmasked pending source. The order and the codes in bits 5:0 are: line error 000110, then receive ready 000100, then receive timeout (see R5), then transmit empty 000010, then modem change 000000, then flow-off character 010000, then handshake change 100000. Receive ready wins over receive timeout.
- R5: The receive-timeout code is 001100 when fifoEnable is 1 and 000100 when it is 0. Bit 3 never reads 1 while fifoEnable is 0.
- R6: intEnable bit mapping: bit 0 covers receive ready and receive timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem change, bit 4 flow-off character, bit 5 handshake change. A source whose enable bit is 0 never appears in the code.
- R7: When extMode is 0, the flow-off-character and handshake-change sources are ignored as if masked.
- R8: A one-cycle pulse on thrEmptyEvt sets a stored transmit-empty flag. The flag stays set with no further pulse until it is cleared by R9.
- R9: A cycle with rdStrobe high while statusByte[5:0] reads 000010 clears the stored transmit-empty flag, and the next status value already shows the next source. A read while any other code is shown leaves the flag set.
- R10: If thrEmptyEvt pulses in the same cycle as a clearing read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One cycle per software read of the status byte |
| thrEmptyEvt | input | 1 | Pulse: transmit holding register became empty |
| srcLineErr | input | 1 | Level: receive line error pending |
| srcRxReady | input | 1 | Level: receive data ready or trigger level reached |
| srcRxTimeout | input | 1 | Level: receive character timeout |
| srcModem | input | 1 | Level: modem status change |
| srcXoff | input | 1 | Level: flow-off or special character detected |
| srcFlowChg | input | 1 | Level: handshake line change of state |
| intEnable | input | 6 | Per-source enables, mapping in R6 |
| fifoEnable | input | 1 | FIFO mode selected |
| extMode | input | 1 | Allows the two extended levels |
| statusByte | output | 8 | Interrupt identification byte |

## Verification
The assertions take as given that rdStrobe is raised only for a single cycle per read, and that the level sources hold steady for at least one edge, so that each status value follows from the values at the edge before. They also assume thrEmptyEvt is a pulse, even when it is held, since a held pulse only keeps setting the flag. The bench changes every input only at the falling edge. It sweeps all source, enable and mode combinations without issuing a read, so the stored flag never changes during the sweep, and it tests clearing reads separately with single-cycle strobes.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  localparam int NUM_SRC = 7;
  localparam int NUM_EN  = 6;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int CODE_W  = 6;
  localparam int STAT_W  = 8;

  // source slots in priority order, slot 0 highest
  localparam int SLOT_LINE  = 0;
  localparam int SLOT_RXRDY = 1;
  localparam int SLOT_RXTO  = 2;
  localparam int SLOT_THR   = 3;
  localparam int SLOT_MODEM = 4;
  localparam int SLOT_XOFF  = 5;
  localparam int SLOT_FLOW  = 6;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;
  localparam logic [CODE_W-1:0] CODE_THR  = 6'b000010;

  typedef struct packed {
    logic setThr;
    logic clrThr;
  } ctlStrobes_t;

  // which enable bit gates a given slot
  function automatic int enIdxOf(input int slot);
    case (slot)
      SLOT_LINE:  return 2;
      SLOT_RXRDY: return 0;
      SLOT_RXTO:  return 0;
      SLOT_THR:   return 1;
      SLOT_MODEM: return 3;
      SLOT_XOFF:  return 4;
      default:    return 5;
    endcase
  endfunction

  function automatic logic isExtSlot(input int slot);
    return (slot == SLOT_XOFF) || (slot == SLOT_FLOW);
  endfunction

  function automatic logic [CODE_W-1:0] codeOf(input logic [IDX_W-1:0] slot,
                                               input logic fifoOn);
    case (slot)
      3'd0:    codeOf = 6'b000110;
      3'd1:    codeOf = 6'b000100;
      3'd2:    codeOf = fifoOn ? 6'b001100 : 6'b000100;
      3'd3:    codeOf = CODE_THR;
      3'd4:    codeOf = 6'b000000;
      3'd5:    codeOf = 6'b010000;
      default: codeOf = 6'b100000;
    endcase
  endfunction

endpackage

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              thrEmptyEvt,
  input  logic [STAT_W-1:0] statusByte,
  output ctlStrobes_t       strobes
);

  logic showingThr;

  assign showingThr = (statusByte[CODE_W-1:0] == CODE_THR);

  always_comb begin
    strobes.setThr = thrEmptyEvt;
    // a new empty event outranks the read that would clear it
    strobes.clrThr = rdStrobe && showingThr && !thrEmptyEvt;
  end

  // R10: set and clear never issued together
  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setThr, strobes.clrThr}));

  // R9: a read of any other code issues no clear
  a_r9_no_clear_other: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && statusByte[CODE_W-1:0] != CODE_THR) |-> !strobes.clrThr);

endmodule

// File: rtl/uart_iid_dpath.sv
module uart_iid_dpath
  import uart_iid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] levelSrc,
  input  logic [NUM_EN-1:0]  intEnable,
  input  logic               fifoEnable,
  input  logic               extMode,
  output logic [STAT_W-1:0]  statusByte
);

  logic               thrPending;
  logic               thrNext;
  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] reqVec;
  logic               anyHit;
  logic [IDX_W-1:0]   winSlot;
  logic [STAT_W-1:0]  statusNext;

  assign thrNext = strobes.setThr || (thrPending && !strobes.clrThr);

  always_comb begin
    rawVec = levelSrc;
    rawVec[SLOT_THR] = thrNext;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    if (isExtSlot(g)) begin : g_ext
      assign reqVec[g] = rawVec[g] && intEnable[enIdxOf(g)] && extMode;
    end else begin : g_base
      assign reqVec[g] = rawVec[g] && intEnable[enIdxOf(g)];
    end
  end

  always_comb begin
    anyHit  = 1'b0;
    winSlot = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        anyHit  = 1'b1;
        winSlot = IDX_W'(i);
      end
    end
  end

  always_comb begin
    statusNext = {{2{fifoEnable}}, (anyHit ? codeOf(winSlot, fifoEnable) : CODE_IDLE)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrPending <= 1'b0;
      statusByte <= 8'h01;
    end else begin
      thrPending <= thrNext;
      statusByte <= statusNext;
    end
  end

  // R2: mode bits follow the FIFO enable
  a_r2_mode_bits: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusByte[7:6] == {2{$past(fifoEnable)}});

  // R5: no timeout flag outside FIFO mode
  a_r5_legacy_bit3: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnable |=> !statusByte[3]);

  // R4: unmasked line error always wins
  a_r4_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (levelSrc[SLOT_LINE] && intEnable[2]) |=> statusByte[5:0] == 6'b000110);

  // R9: a clear strobe drops the stored flag
  a_r9_thr_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrThr |=> !thrPending);

  // R8: an empty event always leaves the flag set
  a_r8_thr_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setThr |=> thrPending);

  // R6: masked line error never shows its code
  a_r6_line_masked: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable[2] |=> statusByte[5:0] != 6'b000110);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_iid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStrobe,
  input  logic       thrEmptyEvt,
  input  logic       srcLineErr,
  input  logic       srcRxReady,
  input  logic       srcRxTimeout,
  input  logic       srcModem,
  input  logic       srcXoff,
  input  logic       srcFlowChg,
  input  logic [5:0] intEnable,
  input  logic       fifoEnable,
  input  logic       extMode,
  output logic [7:0] statusByte
);

  ctlStrobes_t        strobes;
  logic [NUM_SRC-1:0] levelSrc;

  always_comb begin
    levelSrc             = '0;
    levelSrc[SLOT_LINE]  = srcLineErr;
    levelSrc[SLOT_RXRDY] = srcRxReady;
    levelSrc[SLOT_RXTO]  = srcRxTimeout;
    levelSrc[SLOT_MODEM] = srcModem;
    levelSrc[SLOT_XOFF]  = srcXoff;
    levelSrc[SLOT_FLOW]  = srcFlowChg;
  end

  uart_iid_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rdStrobe   (rdStrobe),
    .thrEmptyEvt(thrEmptyEvt),
    .statusByte (statusByte),
    .strobes    (strobes)
  );

  uart_iid_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .levelSrc   (levelSrc),
    .intEnable  (intEnable),
    .fifoEnable (fifoEnable),
    .extMode    (extMode),
    .statusByte (statusByte)
  );

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       thrEmptyEvt = 1'b0;
  logic [5:0] srcs = '0;   // {flow, xoff, modem, rxto, rxrdy, line}
  logic [5:0] intEnable = '0;
  logic       fifoEnable = 1'b0;
  logic       extMode = 1'b0;
  logic [7:0] statusByte;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .thrEmptyEvt(thrEmptyEvt),
    .srcLineErr(srcs[0]), .srcRxReady(srcs[1]), .srcRxTimeout(srcs[2]),
    .srcModem(srcs[3]), .srcXoff(srcs[4]), .srcFlowChg(srcs[5]),
    .intEnable(intEnable), .fifoEnable(fifoEnable), .extMode(extMode),
    .statusByte(statusByte)
  );

  function automatic logic [7:0] model(input logic [5:0] s, input logic thr,
                                       input logic [5:0] en, input logic fo,
                                       input logic ex);
    logic [5:0] lo;
    lo = 6'b000001;
    if (s[5] && en[5] && ex) lo = 6'b100000;
    if (s[4] && en[4] && ex) lo = 6'b010000;
    if (s[3] && en[3])       lo = 6'b000000;
    if (thr && en[1])        lo = 6'b000010;
    if (s[2] && en[0])       lo = fo ? 6'b001100 : 6'b000100;
    if (s[1] && en[0])       lo = 6'b000100;
    if (s[0] && en[2])       lo = 6'b000110;
    return {fo, fo, lo};
  endfunction

  function automatic string tagOf(input logic [7:0] e, input logic fo, input logic ex);
    if (e[0]) return "R3";
    if (e[3] || (!fo && e[5:0] == 6'b000100)) return "R5";
    if (!ex) return "R7";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (statusByte !== exp) begin
      bad++;
      $display("FAIL %s: statusByte=%02h expected=%02h", tag, statusByte, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [5:0] s, input logic [5:0] en,
                       input logic fo, input logic ex);
    @(negedge clk);
    srcs = s; intEnable = en; fifoEnable = fo; extMode = ex;
  endtask

  initial begin
    // R1: reset value
    repeat (3) tick();
    check("R1", 8'h01);
    srcs = 6'h3F; intEnable = 6'h3F; fifoEnable = 1'b1;
    tick();
    check("R1", 8'h01);
    @(negedge clk); rstN = 1'b1; srcs = '0; intEnable = '0; fifoEnable = 1'b0;
    tick();
    check("R1", 8'h01);

    // exhaustive sweep, stored flag clear then set
    for (int t = 0; t < 2; t++) begin
      if (t == 1) begin
        @(negedge clk); thrEmptyEvt = 1'b1;
        @(negedge clk); thrEmptyEvt = 1'b0;
      end
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 64; e++) begin
          for (int s = 0; s < 64; s++) begin
            logic [7:0] exp;
            drive(6'(s), 6'(e), m[0], m[1]);
            tick();
            exp = model(6'(s), t[0], 6'(e), m[0], m[1]);
            total++;
            if (statusByte !== exp) begin
              bad++;
              $display("FAIL %s/R6 sweep: statusByte=%02h expected=%02h",
                       tagOf(exp, m[0], m[1]), statusByte, exp);
            end
            if (statusByte[7:6] !== {2{m[0]}}) begin
              bad++;
              $display("FAIL R2: bits76=%0b expected=%0b", statusByte[7:6], {2{m[0]}});
            end
          end
        end
      end
    end

    // R8: flag persists from the sweep; R9 read clears it, next source appears
    drive(6'b001000, 6'h3F, 1'b1, 1'b1);   // modem pending below THR
    tick();
    check("R8", 8'hC2);
    @(negedge clk); rdStrobe = 1'b1;
    tick();
    check("R9", 8'hC0);
    @(negedge clk); rdStrobe = 1'b0;
    tick();
    check("R9", 8'hC0);
    // R9: with modem gone, idle, and flag stays cleared when re-enabled
    drive(6'b000000, 6'h3F, 1'b1, 1'b1);
    tick();
    check("R9", 8'hC1);

    // R9: read while another code shows keeps the flag
    @(negedge clk); thrEmptyEvt = 1'b1;
    @(negedge clk); thrEmptyEvt = 1'b0; srcs = 6'b000001;
    tick();
    check("R9", 8'hC6);
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0; srcs = '0;
    tick();
    check("R9", 8'hC2);

    // R6: masked THR is remembered, shown when unmasked
    drive(6'b000000, 6'b111101, 1'b0, 1'b0);
    tick();
    check("R6", 8'h01);
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0; intEnable = 6'h3F;
    tick();
    check("R6", 8'h02);

    // R10: empty event together with a clearing read keeps the flag
    @(negedge clk); rdStrobe = 1'b1; thrEmptyEvt = 1'b1;
    tick();
    check("R10", 8'h02);
    @(negedge clk); rdStrobe = 1'b0; thrEmptyEvt = 1'b0;
    tick();
    check("R10", 8'h02);
    // then a plain read clears it
    @(negedge clk); rdStrobe = 1'b1;
    tick();
    check("R9", 8'h01);
    @(negedge clk); rdStrobe = 1'b0;
    tick();
    check("R3", 8'h01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule